// File: doc/BRIEF.md
# Internal clock postscaler and selector

This block produces a selectable system clock from two internal oscillators. A fast oscillator drives a free-running binary postscaler. The postscaler gives the fast frequency and six power-of-two divisions of it. A separate slow, uncalibrated oscillator is passed through unchanged on one select code. A 3-bit select register, written through a simple write strobe on the fast clock, picks which of the eight sources appears on the clock output. After any reset the register holds the half-rate setting.

Moving between two fast-derived settings needs no start-up delay, because the postscaler keeps running and every tap is always present. A write that moves the select code from the fast family to the slow source, or back, raises a one-cycle request so that the switch sequencer can manage the oscillator start-up. The block also asserts an enable for the slow oscillator when the slow code is selected while the internal oscillator is the system clock source, or when another on-chip consumer asks for that oscillator.

Top module: `internal_clock_select`

## Requirements
- R1: After a synchronous reset on `rst`, the select code is 3'b110 and `clk_out` runs at the fast clock divided by 2.
- R2: Select code 3'b111 puts the undivided fast clock on `clk_out`.
- R3: Select codes 3'b001 to 3'b110 put the fast clock divided by 2^(7-code) on `clk_out`, which is divide by 64 for 3'b001 and divide by 2 for 3'b110. The postscaler counter advances by one on every fast clock edge.
- R4: Select code 3'b000 puts the slow oscillator clock on `clk_out`.
- R5: A write whose new code is 3'b000 while the current code is not, or the reverse, makes `switch_req` high for exactly the one fast clock cycle after the write edge.
- R6: A write that moves between two nonzero codes, or rewrites the current code, leaves `switch_req` low.
- R7: `lf_osc_en` is high when the select code is 3'b000 and `int_src_sel` is high, or when `lf_aux_req` is high. In every other case it is low.
- R8: While `wr_en` is low, `wr_code` has no effect on the select code or on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast internal oscillator clock. It clocks the postscaler and the select register. |
| slow_clk | input | 1 | Slow uncalibrated internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset, sampled on fast_clk |
| wr_en | input | 1 | Write strobe for the select register |
| wr_code | input | 3 | New select code |
| int_src_sel | input | 1 | High when the internal oscillator is the system clock source |
| lf_aux_req | input | 1 | Request for the slow oscillator from other consumers |
| switch_req | output | 1 | One-cycle request to the switch sequencer |
| lf_osc_en | output | 1 | Enable for the slow oscillator |
| clk_out | output | 1 | Selected clock |

## Verification
The bench builds the block with the default 3-bit select field. That gives a 6-stage postscaler, so all eight codes can be swept and every output frequency measured. For each code the bench counts rising edges of `clk_out` over a fixed window of fast cycles and compares the count with the window divided by the expected ratio. Writes are ordered so that every kind of transition occurs: into and out of the slow code, inside the fast family, and rewrites of the same code. All input combinations of the slow-oscillator enable are driven.

// File: rtl/clkps_pkg.sv
package clkps_pkg;
    localparam int SEL_W     = 3;
    localparam int NUM_CODES = 2 ** SEL_W;
    localparam int STAGES    = NUM_CODES - 2;

    typedef logic [SEL_W-1:0]  sel_code_t;
    typedef logic [STAGES-1:0] ps_count_t;

    localparam sel_code_t SEL_RESET = sel_code_t'(NUM_CODES - 2);
    localparam sel_code_t SEL_SLOW  = '0;

    function automatic logic is_slow(input sel_code_t c);
        return c == SEL_SLOW;
    endfunction
endpackage

// File: rtl/clkps_postscaler.sv
module clkps_postscaler
    import clkps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output ps_count_t taps
);
    ps_count_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign taps = cnt_q;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/clkps_select_reg.sv
module clkps_select_reg
    import clkps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  sel_code_t wr_code,
    output sel_code_t code,
    output logic      switch_req
);
    sel_code_t code_q;
    logic      req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= SEL_RESET;
            req_q  <= 1'b0;
        end else begin
            req_q <= wr_en && (is_slow(wr_code) != is_slow(code_q));
            if (wr_en) code_q <= wr_code;
        end
    end

    assign code       = code_q;
    assign switch_req = req_q;

    // R1
    reset_code_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> code_q == SEL_RESET);

    // R5
    req_cause_chk: assert property (@(posedge clk) disable iff (rst)
        switch_req |-> $past(wr_en) && (is_slow($past(code_q)) != is_slow(code_q)));

    // R6
    family_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !is_slow($past(code_q)) && !is_slow(code_q)) |-> !switch_req);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(code_q));
endmodule

// File: rtl/clkps_clock_mux.sv
module clkps_clock_mux
    import clkps_pkg::*;
(
    input  logic      fast_clk,
    input  logic      slow_clk,
    input  ps_count_t taps,
    input  sel_code_t code,
    output logic      clk_out
);
    logic [NUM_CODES-1:0] src;

    assign src[0]           = slow_clk;
    assign src[NUM_CODES-1] = fast_clk;

    for (genvar k = 1; k < NUM_CODES - 1; k++) begin : g_tap
        assign src[k] = taps[NUM_CODES-2-k];
    end

    assign clk_out = src[code];
endmodule

// File: rtl/internal_clock_select.sv
module internal_clock_select
    import clkps_pkg::*;
(
    input  logic       fast_clk,
    input  logic       slow_clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_code,
    input  logic       int_src_sel,
    input  logic       lf_aux_req,
    output logic       switch_req,
    output logic       lf_osc_en,
    output logic       clk_out
);
    ps_count_t taps;
    sel_code_t code;

    clkps_postscaler u_ps (
        .clk  (fast_clk),
        .rst  (rst),
        .taps (taps)
    );

    clkps_select_reg u_sel (
        .clk        (fast_clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_code    (wr_code),
        .code       (code),
        .switch_req (switch_req)
    );

    clkps_clock_mux u_mux (
        .fast_clk (fast_clk),
        .slow_clk (slow_clk),
        .taps     (taps),
        .code     (code),
        .clk_out  (clk_out)
    );

    assign lf_osc_en = (is_slow(code) && int_src_sel) || lf_aux_req;

    // R7
    lf_en_chk: assert property (@(posedge fast_clk) disable iff (rst)
        lf_aux_req |-> lf_osc_en);
endmodule

// File: tb/internal_clock_select_tb.sv
module internal_clock_select_tb;
    logic fast_clk = 1'b0;
    logic slow_clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_code = 3'b000;
    logic int_src_sel = 1'b0;
    logic lf_aux_req = 1'b0;
    logic switch_req, lf_osc_en, clk_out;

    int tests = 0;
    int fails = 0;
    int edge_cnt = 0;
    logic [2:0] cur = 3'b110;
    bit done = 0;

    always #10 fast_clk = ~fast_clk;
    always #500 slow_clk = ~slow_clk;
    always @(posedge clk_out) edge_cnt++;

    internal_clock_select u_dut (
        .fast_clk, .slow_clk, .rst, .wr_en, .wr_code,
        .int_src_sel, .lf_aux_req, .switch_req, .lf_osc_en, .clk_out
    );

    task automatic chk(input string req, input int act, input int exp_lo, input int exp_hi);
        tests++;
        if (act < exp_lo || act > exp_hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
        end
    endtask

    // count clk_out rising edges over 256 fast cycles
    task automatic measure(input string req, input logic [2:0] c);
        int n;
        repeat (4) @(negedge fast_clk);
        edge_cnt = 0;
        repeat (256) @(negedge fast_clk);
        n = edge_cnt;
        if (c == 3'b000) chk(req, n, 4, 6);          // 5120 ns / 1000 ns
        else if (c == 3'b111) chk(req, n, 256, 256);
        else chk(req, n, (256 >> (7 - c)) - 1, (256 >> (7 - c)) + 1);
    endtask

    task automatic write_code(input logic [2:0] c);
        int exp_req;
        exp_req = ((cur == 3'b000) != (c == 3'b000)) ? 1 : 0;
        @(negedge fast_clk);
        wr_en = 1'b1;
        wr_code = c;
        @(negedge fast_clk);
        wr_en = 1'b0;
        chk(exp_req ? "R5 request pulse" : "R6 no request", int'(switch_req), exp_req, exp_req);
        @(negedge fast_clk);
        chk("R5 single cycle", int'(switch_req), 0, 0);
        cur = c;
    endtask

    initial begin
        repeat (5) @(negedge fast_clk);
        rst = 1'b0;
        chk("R1 reset request low", int'(switch_req), 0, 0);
        measure("R1 reset divide by 2", 3'b110);

        // sweep every code downward, then back up through slow
        for (int c = 7; c >= 0; c--) begin
            write_code(3'(c));
            if (c == 7) measure("R2 undivided", 3'(c));
            else if (c == 0) measure("R4 slow source", 3'(c));
            else measure("R3 divided", 3'(c));
        end
        write_code(3'b000);           // R6 rewrite slow code
        write_code(3'b011);           // R5 leave slow
        measure("R3 divide by 16", 3'b011);
        write_code(3'b011);           // R6 same code
        write_code(3'b101);           // R6 inside fast family
        measure("R3 divide by 4", 3'b101);

        // R8: data without strobe ignored
        @(negedge fast_clk);
        wr_code = 3'b000;
        repeat (3) @(negedge fast_clk);
        chk("R8 no request without strobe", int'(switch_req), 0, 0);
        measure("R8 code held", 3'b101);

        // R7: every combination for slow and fast codes
        for (int s = 0; s < 2; s++) begin
            write_code(s ? 3'b000 : 3'b100);
            for (int v = 0; v < 4; v++) begin
                int e;
                @(negedge fast_clk);
                int_src_sel = v[0];
                lf_aux_req = v[1];
                @(negedge fast_clk);
                e = ((s == 1 && v[0]) || v[1]) ? 1 : 0;
                chk("R7 slow enable", int'(lf_osc_en), e, e);
            end
        end

        // R1 again: reset from slow code restores divide by 2
        @(negedge fast_clk);
        rst = 1'b1;
        repeat (2) @(negedge fast_clk);
        rst = 1'b0;
        cur = 3'b110;
        chk("R1 request cleared", int'(switch_req), 0, 0);
        measure("R1 post reset divide by 2", 3'b110);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge fast_clk);
                tests++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule